// File: doc/BRIEF.md
# Three-Bank Resynchronizable Clock Divider

This block derives three slower clocks from one fast oscillator clock, which is nominally in the 600 to 1000 MHz range. Each of the three banks (A, B and C) has its own 3-bit ratio select and its own enable. The available ratios are all even, so each bank output has a 50% duty cycle. The bank outputs therefore cover roughly 33 to 500 MHz. Bank B copies its divided clock onto nine output lines, and banks A and C each copy theirs onto two.

A single active-low restart line is shared by all three banks. It first passes through a two-flop synchronizer in the fast clock domain. While the synchronized level is low, every bank is held at count zero with its output low. When the level returns high, all enabled banks start in the same cycle with a rising edge, so their edges are aligned. The intended use is to change one or more selects and then pulse the line high-low-high.

A select change made while a bank runs is taken only at the end of a full output period. As a result, no shortened pulse is ever produced.

Top module: `tri_bank_clkdiv`

## Requirements
- R1: Select code to divide ratio: 3'b000→2, 3'b001→4, 3'b010→6, 3'b011→8, 3'b100→10, 3'b101→12, 3'b110→18, 3'b111→18.
- R2: While running, each bank output is high for exactly ratio/2 fast cycles and low for ratio/2 fast cycles.
- R3: While rst_n is low, all outputs are low and all banks are held.
- R4: Code 3'b111 selects the slowest ratio (18). After reset is released with sync_n_in high and all selects at 3'b111, every bank runs at ratio 18.
- R5: A low level on sync_n_in forces every output low from the third rising clock edge after the low level is first sampled, and keeps it low while the level stays low.
- R6: When sync_n_in returns high, every enabled bank output goes high at the third rising edge after the high level is first sampled, in the same cycle for all banks. Each bank then follows its selected ratio.
- R7: A select change made while a bank runs takes effect only at the rising edge that ends the current full output period. The high and low phases already under way keep the old length.
- R8: With its enable low, a bank output is low from the next edge. On the first edge after the enable returns high (with sync_n_in high), the output goes high and a fresh period begins.
- R9: out_b carries 9 identical copies of bank B's clock; out_a and out_c carry 2 identical copies of their bank clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock (oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n_in | input | 1 | Shared restart line, low holds all banks, asynchronous |
| en_a | input | 1 | Bank A enable |
| en_b | input | 1 | Bank B enable |
| en_c | input | 1 | Bank C enable |
| sel_a | input | 3 | Bank A ratio select |
| sel_b | input | 3 | Bank B ratio select |
| sel_c | input | 3 | Bank C ratio select |
| out_a | output | 2 | Bank A clock copies |
| out_b | output | 9 | Bank B clock copies |
| out_c | output | 2 | Bank C clock copies |

## Verification
The main function is tried with six select triples that give the three banks different ratios. Together they cover every code, including both codes that map to 18. Each output trace is compared bit by bit against a waveform computed from the ratio. Any wrong ratio, unequal duty or misaligned start therefore shows up as a sample mismatch. Directed runs cover the default after reset, a select change in the middle of a period (old period completed versus cut short), the hold from the restart line, and restarting one bank through its enable.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SEL_W    = 3;
    localparam int NUM_BANK = 3;
    localparam int MAX_HALF = 9;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    typedef logic [CNT_W-1:0] half_t;

    // Half of the divide ratio for a select code; 110 and 111 both give 18.
    function automatic half_t half_of(input logic [SEL_W-1:0] code);
        half_t h;
        case (code)
            3'd0:    h = half_t'(1);
            3'd1:    h = half_t'(2);
            3'd2:    h = half_t'(3);
            3'd3:    h = half_t'(4);
            3'd4:    h = half_t'(5);
            3'd5:    h = half_t'(6);
            default: h = half_t'(MAX_HALF);
        endcase
        return h;
    endfunction

    typedef struct packed {
        logic  live;
        logic  out;
        half_t cnt;
        half_t half;
    } bank_st_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_st_t;
endpackage

// File: rtl/restart_sync.sv
module restart_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    import clkdiv_pkg::*;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.s2;

    // R5
    hold_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !async_i |=> ##1 !level_o);
endmodule

// File: rtl/bank_divider.sv
module bank_divider #(
    parameter int SW = clkdiv_pkg::SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          en_i,
    input  logic [SW-1:0] sel_i,
    output logic          clk_o
);
    import clkdiv_pkg::*;

    bank_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == half_t'(st_q.half - half_t'(1)));
        if (!run_i || !en_i) begin
            st_d.live = 1'b0;
            st_d.out  = 1'b0;
            st_d.cnt  = '0;
            st_d.half = half_of(sel_i);
        end else if (!st_q.live) begin
            st_d.live = 1'b1;
            st_d.out  = 1'b1;
            st_d.cnt  = '0;
            st_d.half = half_of(sel_i);
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.out = ~st_q.out;
            if (!st_q.out) st_d.half = half_of(sel_i);
        end else begin
            st_d.cnt = half_t'(st_q.cnt + half_t'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= half_of('1);
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.out;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.half);

    // R7
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && run_i && en_i && st_q.out) |=> $stable(st_q.half));

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!clk_o && st_q.cnt == '0));

    // R1
    half_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half inside {half_t'(1), half_t'(2), half_t'(3), half_t'(4),
                          half_t'(5), half_t'(6), half_t'(9)});
endmodule

// File: rtl/tri_bank_clkdiv.sv
module tri_bank_clkdiv #(
    parameter int FAN_A = 2,
    parameter int FAN_B = 9,
    parameter int FAN_C = 2
) (
    input  logic                       clk_fast,
    input  logic                       rst_n,
    input  logic                       sync_n_in,
    input  logic                       en_a,
    input  logic                       en_b,
    input  logic                       en_c,
    input  logic [clkdiv_pkg::SEL_W-1:0] sel_a,
    input  logic [clkdiv_pkg::SEL_W-1:0] sel_b,
    input  logic [clkdiv_pkg::SEL_W-1:0] sel_c,
    output logic [FAN_A-1:0]           out_a,
    output logic [FAN_B-1:0]           out_b,
    output logic [FAN_C-1:0]           out_c
);
    import clkdiv_pkg::*;

    logic             run;
    logic [SEL_W-1:0] sel_v [NUM_BANK];
    logic             en_v  [NUM_BANK];
    logic             bclk  [NUM_BANK];

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign sel_v[2] = sel_c;
    assign en_v[0]  = en_a;
    assign en_v[1]  = en_b;
    assign en_v[2]  = en_c;

    restart_sync u_sync (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .async_i (sync_n_in),
        .level_o (run)
    );

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        bank_divider #(.SW(SEL_W)) u_div (
            .clk   (clk_fast),
            .rst_n (rst_n),
            .run_i (run),
            .en_i  (en_v[g]),
            .sel_i (sel_v[g]),
            .clk_o (bclk[g])
        );
    end

    assign out_a = {FAN_A{bclk[0]}};
    assign out_b = {FAN_B{bclk[1]}};
    assign out_c = {FAN_C{bclk[2]}};
endmodule

// File: tb/sim_tri_bank_clkdiv.sv
module sim_tri_bank_clkdiv;
    localparam int WIN = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       en_a = 1'b1, en_b = 1'b1, en_c = 1'b1;
    logic [2:0] sel_a = 3'b111, sel_b = 3'b111, sel_c = 3'b111;
    logic [1:0] out_a;
    logic [8:0] out_b;
    logic [1:0] out_c;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic smp_a [WIN];
    logic smp_b [WIN];
    logic smp_c [WIN];
    int   fan_bad;

    // {sel_a, sel_b, sel_c, ratio_a, ratio_b, ratio_c}
    localparam logic [23:0] VEC [6] = '{
        {3'd0, 3'd1, 3'd2, 5'd2,  5'd4,  5'd6},
        {3'd3, 3'd4, 3'd5, 5'd8,  5'd10, 5'd12},
        {3'd6, 3'd7, 3'd0, 5'd18, 5'd18, 5'd2},
        {3'd7, 3'd7, 3'd7, 5'd18, 5'd18, 5'd18},
        {3'd5, 3'd3, 3'd1, 5'd12, 5'd8,  5'd4},
        {3'd2, 3'd6, 3'd4, 5'd6,  5'd18, 5'd10}
    };

    tri_bank_clkdiv u0 (
        .clk_fast (clk), .rst_n (rst_n), .sync_n_in (sync_n),
        .en_a (en_a), .en_b (en_b), .en_c (en_c),
        .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c),
        .out_a (out_a), .out_b (out_b), .out_c (out_c)
    );

    always #5 clk = ~clk;

    function automatic logic wave(input int i, input int start, input int ratio);
        if (i < start) return 1'b0;
        return ((i - start) % ratio) < (ratio / 2);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic capture();
        fan_bad = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            smp_a[i] = out_a[0];
            smp_b[i] = out_b[0];
            smp_c[i] = out_c[0];
            if (!(out_a == '0 || out_a == '1) || !(out_b == '0 || out_b == '1)
                || !(out_c == '0 || out_c == '1)) fan_bad++;
        end
    endtask

    // compare one captured trace against a waveform starting at 'start'
    task automatic cmp(input int bank, input int start, input int ratio, input string req);
        int bad = 0;
        int first = -1;
        logic v;
        for (int i = 0; i < WIN; i++) begin
            v = (bank == 0) ? smp_a[i] : (bank == 1) ? smp_b[i] : smp_c[i];
            if (v !== wave(i, start, ratio)) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, first, -1);
    endtask

    initial begin
        // R3: reset state
        repeat (3) @(negedge clk);
        chk(out_a == '0 && out_b == '0 && out_c == '0, "R3 reset outputs low",
            int'({out_a, out_b, out_c}), 0);

        // R4: default code 111 after reset, ratio 18 everywhere
        rst_n = 1'b1;
        capture();
        cmp(0, 2, 18, "R4 default A");
        cmp(1, 2, 18, "R4 default B");
        cmp(2, 2, 18, "R4 default C");

        // R1 R2 R6 R9: table of select triples
        for (int v = 0; v < 6; v++) begin
            @(negedge clk);
            sync_n = 1'b0;
            sel_a = VEC[v][23:21];
            sel_b = VEC[v][20:18];
            sel_c = VEC[v][17:15];
            repeat (4) @(negedge clk);
            sync_n = 1'b1;
            capture();
            cmp(0, 2, int'(VEC[v][14:10]), "R1 R2 R6 bank A");
            cmp(1, 2, int'(VEC[v][9:5]),   "R1 R2 R6 bank B");
            cmp(2, 2, int'(VEC[v][4:0]),   "R1 R2 R6 bank C");
            chk(fan_bad == 0, "R9 copies identical", fan_bad, 0);
        end

        // R5: hold by the restart line
        begin
            int bad = 0;
            @(negedge clk);
            sync_n = 1'b0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (i >= 2 && (out_a != '0 || out_b != '0 || out_c != '0)) bad++;
            end
            chk(bad == 0, "R5 hold low", bad, 0);
        end

        // R7: mid-period change on bank A from ratio 6 to 18
        sel_a = 3'd2; sel_b = 3'd2; sel_c = 3'd2;
        repeat (2) @(negedge clk);
        sync_n = 1'b1;
        begin
            int bad = 0;
            logic exp;
            for (int i = 0; i < WIN; i++) begin
                @(negedge clk);
                exp = (i < 8) ? wave(i, 2, 6) : wave(i, 8, 18);
                if (out_a[0] !== exp) bad++;
                if (i == 5) sel_a = 3'd6;
            end
            chk(bad == 0, "R7 change at period end", bad, 0);
        end

        // R8: enable on bank C
        @(negedge clk);
        en_c = 1'b0;
        sel_c = 3'd1;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_c != '0) bad++;
            end
            chk(bad == 0, "R8 disabled bank low", bad, 0);
        end
        en_c = 1'b1;
        capture();
        cmp(2, 0, 4, "R8 bank restart on enable");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule